// File: doc/BRIEF.md
# Three-Channel Timer Interrupt and Sync Controller

This block holds the logic that three timer channels share. For each channel it keeps eight sticky event flags and an interrupt mask. The mask is changed only through two write-only strobe registers: one sets mask bits and one clears them. Because of this, software never needs a read-modify-write sequence to arm or disarm a single source. Each channel drives one interrupt line, which is high whenever a flagged event is also unmasked.

The block also offers a shared control word. Writing a one to bit 0 of it sends a reset pulse to all three channel counters in the same cycle. A shared mode word selects, for each channel, the source of its external clock. The source can be that channel's own pin, nothing, or the A output of one of the two sibling channels, so channels can be chained. The counters are not part of this block. They appear only as event-flag inputs, A-output inputs, reset-pulse outputs and external-clock outputs.

Software reaches the block through a simple register port. Writes are strobed. Read data is combinational from the address. A read strobe to a channel's status address clears that channel's flags.

Top module: `tmr_irq_sync`

## Requirements
- R1: Writing to a channel's enable address (channel base + 0x4) sets each mask bit whose data bit is 1. Mask bits written as 0 keep their value. The new mask is visible from the next cycle.
- R2: Writing to a channel's disable address (channel base + 0x8) clears each mask bit whose data bit is 1. Mask bits written as 0 keep their value.
- R3: The mask reads back at channel base + 0xC and the mode word reads back at 0x34. The enable and disable addresses read as zero. Channel bases are 0x00, 0x10 and 0x20.
- R4: A one-cycle pulse on flag input bit 8*c+k sets status bit k of channel c, which reads at the channel base. The bit stays set until a read strobe to that address clears it. The read returns the value held before the clear. A flag arriving in the same cycle as the clear survives. Bits 0..7 are: overflow, load overrun, compare A, compare B, compare C, A loaded, B loaded and external trigger.
- R5: irq_o[c] is high exactly when status and mask of channel c share a set bit. It follows a flag or mask change from the next cycle, with no further delay.
- R6: Writing address 0x30 with data bit 0 set drives cnt_rst_o to 3'b111 for exactly the next cycle. The same write with bit 0 clear produces no pulse.
- R7: Mode bits 1:0 choose channel 0's external clock. Code 0 selects pin 0, code 1 gives a constant 0, code 2 selects channel 1's A output and code 3 selects channel 2's A output.
- R8: Mode bits 3:2 choose channel 1's external clock: pin 1, none, A of channel 0, A of channel 2. Mode bits 5:4 choose channel 2's: pin 2, none, A of channel 0, A of channel 1.
- R9: After reset, all masks, flags and the mode word are zero. No interrupt or counter reset is asserted, and every channel's clock follows its own pin.
- R10: A mask write or a flag on one channel leaves the other channels' masks, flags and interrupt lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Read strobe; clears status on a status address |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| flag_set_i | input | 24 | Event pulses, 8 per channel |
| ext_pin_i | input | 3 | External clock pins, one per channel |
| tioa_i | input | 3 | A outputs of the three channels |
| xclk_o | output | 3 | Selected external clock per channel |
| cnt_rst_o | output | 3 | Counter reset pulse per channel |
| irq_o | output | 3 | Interrupt line per channel |

## Verification
A mask bit lost or set by the strobe logic shows at the mask readback in the cycle after the write. If its flag is pending, it also shows on irq_o in that same cycle. A status bit that is cleared too early, or that survives a clear, shows at the next status read and on the interrupt line right after the clear edge. A mis-routed selector changes xclk_o combinationally, as soon as the mode word is registered. Any sync fault shows on cnt_rst_o in the single cycle after the control write, as a missing bit, a channel that fires alone, or a pulse that lasts too long.

// File: rtl/tmr_irq_sync_pkg.sv
package tmr_irq_sync_pkg;
  localparam int NUM_CH    = 3;
  localparam int NUM_FLAGS = 8;
  localparam int SEL_W     = 2;

  localparam logic [7:0] CH_STRIDE = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h00;
  localparam logic [7:0] OFF_IEN   = 8'h04;
  localparam logic [7:0] OFF_IDIS  = 8'h08;
  localparam logic [7:0] OFF_MASK  = 8'h0C;
  localparam logic [7:0] ADDR_CTRL = 8'h30;
  localparam logic [7:0] ADDR_MODE = 8'h34;

  // flag positions within a channel
  localparam int FLG_OVF  = 0;
  localparam int FLG_LOVR = 1;
  localparam int FLG_CMPA = 2;
  localparam int FLG_CMPB = 3;
  localparam int FLG_CMPC = 4;
  localparam int FLG_LDA  = 5;
  localparam int FLG_LDB  = 6;
  localparam int FLG_ETRG = 7;

  typedef enum logic [SEL_W-1:0] {
    XSEL_PIN  = 2'd0,
    XSEL_NONE = 2'd1,
    XSEL_LO   = 2'd2,
    XSEL_HI   = 2'd3
  } xsel_e;

  function automatic logic [7:0] chan_addr(int ch, logic [7:0] off);
    return 8'(ch * 16) + off;
  endfunction
endpackage

// File: rtl/tmr_chan_irq.sv
module tmr_chan_irq
  import tmr_irq_sync_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ien_we_i,
  input  logic          idis_we_i,
  input  logic [NF-1:0] wbits_i,
  input  logic          stat_clr_i,
  input  logic [NF-1:0] flag_set_i,
  output logic [NF-1:0] stat_o,
  output logic [NF-1:0] mask_o,
  output logic          irq_o
);
  logic [NF-1:0] mask_q, mask_d, stat_q, stat_d;

  always_comb begin
    mask_d = mask_q;
    if (ien_we_i)  mask_d = mask_d | wbits_i;
    if (idis_we_i) mask_d = mask_d & ~wbits_i;
  end

  // new events win over a same-cycle clear
  always_comb begin
    stat_d = stat_q;
    if (stat_clr_i) stat_d = '0;
    stat_d = stat_d | flag_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);
endmodule

// File: rtl/tmr_xclk_sel.sv
module tmr_xclk_sel
  import tmr_irq_sync_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              pin_i,
  input  logic [NUM_CH-1:0] tioa_i,
  output logic              xclk_o
);
  // the two siblings, lower index first
  localparam int LO = (CH == 0) ? 1 : 0;
  localparam int HI = (CH == 2) ? 1 : 2;

  always_comb begin
    unique case (xsel_e'(sel_i))
      XSEL_PIN:  xclk_o = pin_i;
      XSEL_NONE: xclk_o = 1'b0;
      XSEL_LO:   xclk_o = tioa_i[LO];
      XSEL_HI:   xclk_o = tioa_i[HI];
      default:   xclk_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_irq_sync.sv
module tmr_irq_sync
  import tmr_irq_sync_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NF     = NUM_FLAGS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic                 bus_re_i,
  input  logic [7:0]           bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  input  logic [NUM_CH*NF-1:0] flag_set_i,
  input  logic [NUM_CH-1:0]    ext_pin_i,
  input  logic [NUM_CH-1:0]    tioa_i,
  output logic [NUM_CH-1:0]    xclk_o,
  output logic [NUM_CH-1:0]    cnt_rst_o,
  output logic [NUM_CH-1:0]    irq_o
);
  localparam int FLAT_W = NUM_CH * NF;
  localparam int MODE_W = NUM_CH * SEL_W;

  logic [FLAT_W-1:0] stat_all, mask_all;
  logic [MODE_W-1:0] mode_q;
  logic [NUM_CH-1:0] sync_q;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:MODE_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ien_we, idis_we, clr;
    assign ien_we  = bus_we_i && (bus_addr_i == chan_addr(c, OFF_IEN));
    assign idis_we = bus_we_i && (bus_addr_i == chan_addr(c, OFF_IDIS));
    assign clr     = bus_re_i && (bus_addr_i == chan_addr(c, OFF_STAT));

    tmr_chan_irq #(.NF(NF)) u_irq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ien_we_i   (ien_we),
      .idis_we_i  (idis_we),
      .wbits_i    (bus_wdata_i[NF-1:0]),
      .stat_clr_i (clr),
      .flag_set_i (flag_set_i[c*NF +: NF]),
      .stat_o     (stat_all[c*NF +: NF]),
      .mask_o     (mask_all[c*NF +: NF]),
      .irq_o      (irq_o[c])
    );

    tmr_xclk_sel #(.CH(c)) u_sel (
      .sel_i  (mode_q[c*SEL_W +: SEL_W]),
      .pin_i  (ext_pin_i[c]),
      .tioa_i (tioa_i),
      .xclk_o (xclk_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      sync_q <= '0;
    end else begin
      if (bus_we_i && bus_addr_i == ADDR_MODE) mode_q <= bus_wdata_i[MODE_W-1:0];
      sync_q <= {NUM_CH{bus_we_i && bus_addr_i == ADDR_CTRL && bus_wdata_i[0]}};
    end
  end

  assign cnt_rst_o = sync_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_MODE) bus_rdata_o = DATA_W'(mode_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr_i == chan_addr(c, OFF_STAT)) bus_rdata_o = DATA_W'(stat_all[c*NF +: NF]);
      if (bus_addr_i == chan_addr(c, OFF_MASK)) bus_rdata_o = DATA_W'(mask_all[c*NF +: NF]);
    end
  end
endmodule

// File: rtl/tmr_irq_sync_chk.sv
module tmr_irq_sync_chk
  import tmr_irq_sync_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_we_i,
  input logic [7:0]  bus_addr_i,
  input logic [31:0] bus_wdata_i,
  input logic [23:0] flag_set_i,
  input logic [23:0] stat_all,
  input logic [23:0] mask_all,
  input logic [2:0]  cnt_rst_o,
  input logic [2:0]  irq_o
);
  // R1
  en_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_IEN) |=>
      ((mask_all[7:0] & $past(bus_wdata_i[7:0])) == $past(bus_wdata_i[7:0])));

  // R2
  dis_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_IDIS) |=>
      ((mask_all[7:0] & $past(bus_wdata_i[7:0])) == 8'h00));

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set_i) |=> ((stat_all & $past(flag_set_i)) == $past(flag_set_i)));

  // R5
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|(stat_all & mask_all)));

  // R6
  sync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_CTRL && bus_wdata_i[0]) |=> (cnt_rst_o == 3'b111));

  // R6
  sync_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_o != 3'b000) |-> (cnt_rst_o == 3'b111));
endmodule

bind tmr_irq_sync tmr_irq_sync_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .flag_set_i  (flag_set_i),
  .stat_all    (stat_all),
  .mask_all    (mask_all),
  .cnt_rst_o   (cnt_rst_o),
  .irq_o       (irq_o)
);

// File: tb/tmr_irq_sync_bench.sv
module tmr_irq_sync_bench;
  localparam int SIG_RD = 0, SIG_IRQ = 1, SIG_XCLK = 2, SIG_RST = 3;

  typedef struct {
    int          sig;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [23:0] flags = '0;
  logic [2:0]  pins = '0, tioa = '0;
  logic [2:0]  xclk, cnt_rst, irq;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  tmr_irq_sync u_tmr_irq_sync (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .flag_set_i(flags), .ext_pin_i(pins), .tioa_i(tioa),
    .xclk_o(xclk), .cnt_rst_o(cnt_rst), .irq_o(irq)
  );

  // expected clock routing, written from R7/R8
  function automatic logic [2:0] ref_xclk(logic [5:0] m, logic [2:0] p, logic [2:0] a);
    logic [2:0] r;
    case (m[1:0]) 2'd0: r[0] = p[0]; 2'd1: r[0] = 1'b0; 2'd2: r[0] = a[1]; default: r[0] = a[2]; endcase
    case (m[3:2]) 2'd0: r[1] = p[1]; 2'd1: r[1] = 1'b0; 2'd2: r[1] = a[0]; default: r[1] = a[2]; endcase
    case (m[5:4]) 2'd0: r[2] = p[2]; 2'd1: r[2] = 1'b0; 2'd2: r[2] = a[0]; default: r[2] = a[1]; endcase
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic expect_v(int sig, logic [31:0] e, string req);
    item_t it;
    it.sig = sig; it.exp = e; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string req);
    addr = a;
    expect_v(SIG_RD, e, req);
    step();
  endtask

  task automatic rd_clr(logic [7:0] a, logic [31:0] e, string req);
    addr = a; re = 1'b1;
    expect_v(SIG_RD, e, req);
    step();
    re = 1'b0;
  endtask

  task automatic pulse(int idx);
    flags[idx] = 1'b1;
    step();
    flags = '0;
  endtask

  // monitor: compares mid-cycle, away from both edges
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sig)
          SIG_RD:   act = rdata;
          SIG_IRQ:  act = {29'd0, irq};
          SIG_XCLK: act = {29'd0, xclk};
          default:  act = {29'd0, cnt_rst};
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) step();
    rst_n = 1'b1;
    step();

    // R9 reset state
    pins = 3'b101;
    expect_v(SIG_IRQ, 0, "R9");
    expect_v(SIG_RST, 0, "R9");
    expect_v(SIG_XCLK, ref_xclk(6'h00, 3'b101, 3'b000), "R9");
    rd(8'h0C, 0, "R9");
    rd(8'h00, 0, "R9");
    rd(8'h34, 0, "R9");

    // R1 enable strobes
    wr(8'h04, 32'h05);
    rd(8'h0C, 32'h05, "R1");
    wr(8'h04, 32'h80);
    rd(8'h0C, 32'h85, "R1");
    rd(8'h04, 0, "R3");

    // R2 disable strobes
    wr(8'h08, 32'h04);
    rd(8'h0C, 32'h81, "R2");
    rd(8'h08, 0, "R3");
    rd(8'h1C, 0, "R10");

    // R4/R5 flags and interrupt
    pulse(1);                       // load overrun, masked off
    expect_v(SIG_IRQ, 3'b000, "R5");
    rd(8'h00, 32'h02, "R4");
    pulse(0);                       // overflow, masked on
    expect_v(SIG_IRQ, 3'b001, "R5");
    rd(8'h00, 32'h03, "R4");
    rd_clr(8'h00, 32'h03, "R4");
    expect_v(SIG_IRQ, 3'b000, "R5");
    rd(8'h00, 0, "R4");

    // R4 flag beats same-cycle clear
    addr = 8'h00; re = 1'b1; flags[7] = 1'b1;
    expect_v(SIG_RD, 0, "R4");
    step();
    re = 1'b0; flags = '0;
    rd(8'h00, 32'h80, "R4");
    expect_v(SIG_IRQ, 3'b001, "R5");

    // R10 channel 2 independent
    pulse(2*8 + 4);
    expect_v(SIG_IRQ, 3'b001, "R10");
    rd(8'h20, 32'h10, "R10");
    rd(8'h00, 32'h80, "R10");
    wr(8'h24, 32'h10);
    expect_v(SIG_IRQ, 3'b101, "R5");
    rd(8'h0C, 32'h81, "R10");

    // R6 sync
    expect_v(SIG_RST, 0, "R6");
    wr(8'h30, 32'h1);
    expect_v(SIG_RST, 3'b111, "R6");
    step();
    expect_v(SIG_RST, 0, "R6");
    wr(8'h30, 32'h0);
    expect_v(SIG_RST, 0, "R6");
    step();

    // R7 channel 0 selector
    pins = 3'b000; tioa = 3'b010;
    wr(8'h34, 32'h02);
    expect_v(SIG_XCLK, 3'b001, "R7");
    step();
    wr(8'h34, 32'h03);
    expect_v(SIG_XCLK, 3'b000, "R7");
    step();
    pins = 3'b111;
    wr(8'h34, 32'h01);
    expect_v(SIG_XCLK, 3'b110, "R7");
    step();

    // R8 channel 1 and 2 selectors
    pins = 3'b000; tioa = 3'b001;
    wr(8'h34, 32'h38);
    expect_v(SIG_XCLK, 3'b010, "R8");
    step();
    tioa = 3'b110;
    expect_v(SIG_XCLK, 3'b100, "R8");
    step();
    wr(8'h34, 32'h3C);
    expect_v(SIG_XCLK, ref_xclk(6'h3C, 3'b000, 3'b110), "R8");
    rd(8'h34, 32'h3C, "R3");

    step();
    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule